// File: doc/BRIEF.md
# Page Buffer and Timed Write Controller

This block sits behind the serial protocol engine of a small byte-wide nonvolatile memory. While a write frame is open, it gathers the data bytes into a small page buffer. Each byte is placed by its offset within the page, and a per-entry valid bit records which offsets the frame actually carried. A frame opens at a START event. A STOP event closes it and launches the commit. Once the commit launches, the block walks the buffer in ascending offset order and emits one array write strobe for each valid entry. It then holds an internally timed write window whose length is a parameter counted in system clock cycles.

The `busy` output is high for the whole commit and the whole timed window. The front end uses it to stay silent on the bus during that time. While `busy` is high, every frame input (START, STOP and bytes) is dropped. When the write-protect input is high at STOP, the frame is closed without programming anything.

Top module: `pgbuf_wr_ctrl`

## Requirements
- R1: Out of reset, `busy`, `arr_we` and `commit_done` are low.
- R2: A qualifying STOP causes one `arr_we` cycle per valid entry. Offset i is presented in the (i+1)-th cycle after the edge that samples STOP. The address is `{row, offset}`, where row is the `byte_row` of the last accepted byte and the offset sits in the low log2(PAGE_BYTES) bits. The data is the last byte received at that offset.
- R3: Only offsets that received a byte in the current frame are written. Partial pages of 1 to PAGE_BYTES entries produce exactly that many writes.
- R4: A later byte at an offset already filled in the same frame replaces the earlier one. Offsets that wrap past the page end therefore overwrite, and each offset is written at most once.
- R5: An accepted START empties the valid mask. Only bytes that arrive after the last START of a frame are committed.
- R6: A STOP that closes a frame with no accepted byte, or a STOP with no open frame, starts nothing: `busy` stays low.
- R7: With `wp` high at STOP, no array write occurs, `busy` stays low and the frame is closed.
- R8: `busy` rises in the cycle after a qualifying STOP is sampled and stays high for exactly PAGE_BYTES + TWR_CYCLES cycles.
- R9: `commit_done` pulses for one cycle, in the last cycle in which `busy` is high.
- R10: While `busy` is high, START, STOP and byte strobes are ignored. None of them opens, closes or fills a frame, and none of them extends the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | START event strobe from the protocol engine |
| stop_evt | input | 1 | STOP event strobe from the protocol engine |
| byte_vld | input | 1 | A received data byte is present |
| byte_off | input | log2(PAGE_BYTES) | In-page offset of the byte |
| byte_row | input | ADDR_W-log2(PAGE_BYTES) | Page row of the byte |
| byte_dat | input | DATA_W | Data byte |
| wp | input | 1 | Write protect; high blocks the commit |
| busy | output | 1 | Commit or timed write cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_dat | output | DATA_W | Array write data |
| commit_done | output | 1 | One-cycle pulse at the end of the write cycle |

## Verification
A corrupted valid mask or buffer entry appears at the array port during the next commit. It shows as a missing, extra, or wrongly valued write within PAGE_BYTES cycles of the STOP. A sequencer or timer that miscounts shows as a busy window of the wrong length, or as a `commit_done` pulse that is not aligned with the fall of `busy`. The error is visible at the end of that same write cycle. An input that leaks through while `busy` is high leaves no trace until the following STOP. The bench therefore sends a stray frame during a write cycle and then a bare STOP afterwards, which must start nothing.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_WRITE = 2'd1,
      SEQ_WAIT  = 2'd2
   } seq_state_t;

endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
   parameter int PAGE_BYTES = 8,
   parameter int DATA_W     = 8,
   parameter bit CLEAR_DATA = 1'b1,
   localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  wr_en,
   input  logic [OFF_W-1:0]      wr_off,
   input  logic [DATA_W-1:0]     wr_dat,
   input  logic [OFF_W-1:0]      rd_off,
   output logic [DATA_W-1:0]     rd_dat,
   output logic [PAGE_BYTES-1:0] mask
);

   logic [DATA_W-1:0] entry [PAGE_BYTES];

   // valid mask: clear wins over a simultaneous write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '0;
      end else if (clr) begin
         mask <= '0;
      end else if (wr_en) begin
         mask[wr_off] <= 1'b1;
      end
   end

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
      logic hit;
      assign hit = wr_en && !clr && (wr_off == OFF_W'(g));
      if (CLEAR_DATA) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               entry[g] <= '0;
            end else if (hit) begin
               entry[g] <= wr_dat;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) begin
               entry[g] <= wr_dat;
            end
         end
      end
   end

   assign rd_dat = entry[rd_off];

   AST_CLR_EMPTIES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (mask == '0)); // R5
   AST_WR_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> mask[$past(wr_off)]); // R3
   AST_WR_LANDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> (entry[$past(wr_off)] == $past(wr_dat))); // R4

endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
   parameter int TWR_CYCLES = 500000,
   localparam int CNT_W     = $clog2(TWR_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic running,
   output logic last
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (launch) begin
         running <= 1'b1;
         cnt     <= '0;
      end else if (running) begin
         if (cnt == CNT_W'(TWR_CYCLES - 1)) begin
            running <= 1'b0;
            cnt     <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign last = running && (cnt == CNT_W'(TWR_CYCLES - 1));

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt < CNT_W'(TWR_CYCLES))); // R8
   AST_LAST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !launch) |=> !running); // R9

endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
   import pgbuf_pkg::*;
#(
   parameter int PAGE_BYTES = 8,
   localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [PAGE_BYTES-1:0] mask,
   input  logic                  tmr_run,
   input  logic                  tmr_last,
   output logic [OFF_W-1:0]      idx,
   output logic                  we,
   output logic                  tmr_launch,
   output logic                  busy
);

   seq_state_t state, state_nx;
   logic [OFF_W-1:0] idx_nx;

   always_comb begin
      state_nx   = state;
      idx_nx     = idx;
      tmr_launch = 1'b0;
      unique case (state)
         SEQ_IDLE: begin
            if (go) begin
               state_nx = SEQ_WRITE;
               idx_nx   = '0;
            end
         end
         SEQ_WRITE: begin
            if (idx == OFF_W'(PAGE_BYTES - 1)) begin
               state_nx   = SEQ_WAIT;
               idx_nx     = '0;
               tmr_launch = 1'b1;
            end else begin
               idx_nx = idx + 1'b1;
            end
         end
         SEQ_WAIT: begin
            if (tmr_last) begin
               state_nx = SEQ_IDLE;
            end
         end
         default: begin
            state_nx = SEQ_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         idx   <= '0;
      end else begin
         state <= state_nx;
         idx   <= idx_nx;
      end
   end

   assign we   = (state == SEQ_WRITE) && mask[idx];
   assign busy = (state != SEQ_IDLE);

   AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (state == SEQ_IDLE)); // R10
   AST_WAIT_HAS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_WAIT) |-> tmr_run); // R8
   AST_WRITE_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_WRITE) |=> $stable(mask)); // R3

endmodule

// File: rtl/pgbuf_wr_ctrl.sv
module pgbuf_wr_ctrl #(
   parameter int PAGE_BYTES = 8,
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 8,
   parameter int TWR_CYCLES = 500000,
   parameter bit CLEAR_DATA = 1'b1,
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int ROW_W     = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              byte_vld,
   input  logic [OFF_W-1:0]  byte_off,
   input  logic [ROW_W-1:0]  byte_row,
   input  logic [DATA_W-1:0] byte_dat,
   input  logic              wp,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_dat,
   output logic              commit_done
);

   if (PAGE_BYTES < 2 || (1 << OFF_W) != PAGE_BYTES) begin : g_chk_page
      $error("PAGE_BYTES must be a power of two and at least 2");
   end
   if (TWR_CYCLES < 1) begin : g_chk_twr
      $error("TWR_CYCLES must be at least 1");
   end
   if (ADDR_W <= OFF_W) begin : g_chk_addr
      $error("ADDR_W must exceed the offset width");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("DATA_W must be positive");
   end

   logic                  frame_open;
   logic [ROW_W-1:0]      row_q;
   logic [PAGE_BYTES-1:0] mask;
   logic [OFF_W-1:0]      idx;
   logic                  take_start, take_stop, take_byte, go;
   logic                  tmr_launch, tmr_run, tmr_last;

   assign take_start = start_evt && !busy;
   assign take_stop  = stop_evt && !busy && !start_evt;
   assign take_byte  = byte_vld && !busy && frame_open && !start_evt;
   assign go         = take_stop && frame_open && !wp && ((mask != '0) || take_byte);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_open <= 1'b0;
         row_q      <= '0;
      end else begin
         if (take_start) begin
            frame_open <= 1'b1;
         end else if (take_stop) begin
            frame_open <= 1'b0;
         end
         if (take_byte) begin
            row_q <= byte_row;
         end
      end
   end

   pgbuf_store #(
      .PAGE_BYTES (PAGE_BYTES),
      .DATA_W     (DATA_W),
      .CLEAR_DATA (CLEAR_DATA)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (take_start),
      .wr_en  (take_byte),
      .wr_off (byte_off),
      .wr_dat (byte_dat),
      .rd_off (idx),
      .rd_dat (arr_dat),
      .mask   (mask)
   );

   pgbuf_seq #(
      .PAGE_BYTES (PAGE_BYTES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .mask       (mask),
      .tmr_run    (tmr_run),
      .tmr_last   (tmr_last),
      .idx        (idx),
      .we         (arr_we),
      .tmr_launch (tmr_launch),
      .busy       (busy)
   );

   pgbuf_timer #(
      .TWR_CYCLES (TWR_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (tmr_launch),
      .running (tmr_run),
      .last    (tmr_last)
   );

   assign arr_addr    = {row_q, idx};
   assign commit_done = tmr_last;

   AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy); // R2
   AST_WP_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && wp && !busy) |=> !busy); // R7
   AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt)); // R8
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      commit_done |-> busy ##1 !busy); // R9
   AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mask)); // R10
   AST_EMPTY_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && !busy && (mask == '0) && !byte_vld) |=> !busy); // R6

endmodule

// File: tb/pgbuf_wr_ctrl_test.sv
module pgbuf_wr_ctrl_test;

   localparam int PB   = 8;
   localparam int DW   = 8;
   localparam int AW   = 8;
   localparam int TWR  = 20;
   localparam int OW   = 3;
   localparam int RW   = AW - OW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_evt = 1'b0, stop_evt = 1'b0, byte_vld = 1'b0, wp = 1'b0;
   logic [OW-1:0] byte_off = '0;
   logic [RW-1:0] byte_row = '0;
   logic [DW-1:0] byte_dat = '0;
   logic          busy, arr_we, commit_done;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_dat;

   always #5 clk = ~clk;

   pgbuf_wr_ctrl #(
      .PAGE_BYTES (PB), .DATA_W (DW), .ADDR_W (AW), .TWR_CYCLES (TWR), .CLEAR_DATA (1'b1)
   ) uut (
      .clk (clk), .rst_n (rst_n), .start_evt (start_evt), .stop_evt (stop_evt),
      .byte_vld (byte_vld), .byte_off (byte_off), .byte_row (byte_row),
      .byte_dat (byte_dat), .wp (wp), .busy (busy), .arr_we (arr_we),
      .arr_addr (arr_addr), .arr_dat (arr_dat), .commit_done (commit_done)
   );

   int total = 0;
   int bad   = 0;
   int commits = 0;
   int dones = 0;

   // bench model
   logic [DW-1:0]   m_dat [PB];
   logic [PB-1:0]   m_mask = '0;
   logic [RW-1:0]   m_row = '0;
   bit              m_open = 1'b0;
   bit              exp_busy = 1'b0;
   logic [AW+DW-1:0] sb_q [$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor / scoreboard
   int  run = 0;
   bit  prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) begin
            run++;
         end else if (run != 0) begin
            chk(run == PB + TWR, "R8", "busy length", run, PB + TWR);
            run = 0;
         end
         if (arr_we) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R3", "unexpected write addr", int'(arr_addr), -1);
            end else begin
               logic [AW+DW-1:0] e;
               e = sb_q.pop_front();
               chk(arr_addr == e[AW+DW-1:DW], "R2", "write addr",
                   int'(arr_addr), int'(e[AW+DW-1:DW]));
               chk(arr_dat == e[DW-1:0], "R4", "write data",
                   int'(arr_dat), int'(e[DW-1:0]));
            end
         end
         if (commit_done) begin
            dones++;
            chk(busy, "R9", "done outside busy", int'(busy), 1);
         end
         if (prev_done) begin
            chk(!busy, "R9", "busy after done", int'(busy), 0);
         end
         prev_done = commit_done;
      end
   end

   task automatic do_start();
      start_evt = 1'b1;
      @(negedge clk);
      start_evt = 1'b0;
      if (!exp_busy) begin
         m_open = 1'b1;
         m_mask = '0;
      end
   endtask

   task automatic do_byte(input int off, input int row, input int dat);
      byte_vld = 1'b1;
      byte_off = OW'(off);
      byte_row = RW'(row);
      byte_dat = DW'(dat);
      @(negedge clk);
      byte_vld = 1'b0;
      if (!exp_busy && m_open) begin
         m_mask[off] = 1'b1;
         m_dat[off]  = DW'(dat);
         m_row       = RW'(row);
      end
   endtask

   task automatic do_stop(input string req);
      bit q;
      bit was_busy;
      was_busy = exp_busy;
      q = !exp_busy && m_open && (m_mask != '0) && !wp;
      if (q) begin
         for (int i = 0; i < PB; i++) begin
            if (m_mask[i]) sb_q.push_back({m_row, OW'(i), m_dat[i]});
         end
         commits++;
      end
      stop_evt = 1'b1;
      @(negedge clk);
      stop_evt = 1'b0;
      if (!was_busy) begin
         chk(busy == q, req, "busy after stop", int'(busy), int'(q));
         m_open = 1'b0;
      end
      if (q) exp_busy = 1'b1;
   endtask

   task automatic wait_idle(input string req);
      for (int i = 0; i < 400 && busy; i++) @(negedge clk);
      chk(!busy, req, "busy cleared", int'(busy), 0);
      chk(sb_q.size() == 0, req, "pending writes", sb_q.size(), 0);
      exp_busy = 1'b0;
      @(negedge clk);
   endtask

   task automatic idle_gap(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(!busy && !arr_we, "R6", "quiet when idle", int'(busy), 0);
      end
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy, "R1", "busy in reset", int'(busy), 0);
      chk(!arr_we, "R1", "we in reset", int'(arr_we), 0);
      chk(!commit_done, "R1", "done in reset", int'(commit_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !arr_we && !commit_done, "R1", "idle after reset", int'(busy), 0);

      // R2 R8 R9: full page
      do_start();
      for (int i = 0; i < PB; i++) do_byte(i, 5, 8'h10 + i);
      do_stop("R8");
      wait_idle("R2");

      // R3: partial page, out of order
      do_start();
      do_byte(6, 9, 8'hA6);
      do_byte(2, 9, 8'hA2);
      do_stop("R3");
      wait_idle("R3");

      // R4: ten bytes wrap over the page
      do_start();
      for (int k = 0; k < 10; k++) do_byte((4 + k) % PB, 17, 8'h40 + k);
      do_stop("R4");
      wait_idle("R4");

      // R5: repeated START drops earlier bytes
      do_start();
      do_byte(1, 3, 8'h31);
      do_byte(3, 3, 8'h33);
      do_start();
      do_byte(7, 3, 8'h37);
      do_stop("R5");
      wait_idle("R5");

      // R6: empty frame and bare STOP
      do_start();
      do_stop("R6");
      idle_gap(3);
      do_stop("R6");
      idle_gap(3);

      // R7: write protect
      do_start();
      do_byte(0, 2, 8'h55);
      do_byte(1, 2, 8'h66);
      wp = 1'b1;
      do_stop("R7");
      wp = 1'b0;
      idle_gap(4);
      do_stop("R7");
      idle_gap(3);

      // R10: inputs ignored while busy
      do_start();
      do_byte(0, 1, 8'h01);
      do_stop("R10");
      do_start();
      do_byte(3, 6, 8'hEE);
      do_stop("R10");
      wait_idle("R10");
      do_stop("R10");
      idle_gap(4);

      chk(dones == commits, "R9", "done pulses", dones, commits);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule